// File: doc/BRIEF.md
# Synchronous Flow-Through Static RAM with Byte-Lane Writes

This block is a synchronous static RAM for cache-data style storage. On every rising clock edge it captures a word address, the write data and the write qualifiers. A separate burst sequencer supplies the address. Writes land in the array at the edge that ends the write cycle, so no external write pulse is needed.

Reads are flow-through. Once a read address is registered, the array word appears at the data output combinationally in that same cycle, with no output register stage.

Three signals qualify a write:
- Per-lane byte strobes, which only take effect while the write enable is high.
- A global write, which overrides the strobes and the write enable and writes every lane.

Two inputs are asynchronous:
- The output enable gates the output drive at once.
- The sleep input turns the output drive off at once, makes the block ignore new cycles, and keeps the array contents.

Tri-state is modelled by a drive-enable output: a pad layer releases the bus when it is low, and the data output reads zero.

Top module: `sync_ft_sram`

## Requirements
- R1: Address, data, chip select, byte strobes, write enable and global write are taken only at the rising clock edge. A change between edges does not alter the output. Read data for the registered address is valid in the same cycle, with no extra latency.
- R2: Lane k occupies data bits [k*LANE_W +: LANE_W]. It is written when byte strobe k and the write enable are both high in a selected cycle.
- R3: A selected cycle with global write high writes all lanes, whatever the byte strobes and the write enable are.
- R4: A selected cycle with every byte strobe and the write enable high writes all lanes.
- R5: A lane whose strobe is low in a strobed write keeps its previous contents.
- R6: A read cycle is a selected cycle with write enable and global write both low. For the cycle after that edge, with output enable high and sleep low, `dq_oe_o` is 1 and `rdata_o` equals the stored word at the registered address.
- R7: Output enable acts without a clock. While it is low, `dq_oe_o` is 0 and `rdata_o` is 0. Raising it during a read cycle drives the data at once.
- R8: A cycle registered with chip select low neither writes nor drives. Deselection takes effect in the very next cycle.
- R9: A write cycle does not drive the outputs. A read of the same address registered in the immediately following cycle returns the newly written data.
- R10: While sleep is high, `dq_oe_o` is 0 at once. Edges during sleep start no operation, and the array contents are retained.
- R11: An active asynchronous reset leaves the block deselected, so `dq_oe_o` is 0.
- R12: A selected cycle with the write enable high, no byte strobe and global write low writes nothing and does not drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the control registers |
| addr_i | input | ADDR_W | Word address from the burst sequencer |
| cs_i | input | 1 | Chip select, active high |
| be_i | input | LANES | Byte strobes, bit k selects lane k |
| we_i | input | 1 | Write enable qualifying the byte strobes |
| gwe_i | input | 1 | Global write, writes all lanes |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe_o | output | 1 | Output drive enable; low means high impedance |

## Verification
The rising edge that ends a write cycle both commits the write into the array and registers the next cycle's address. A read of the just-written address, issued in the cycle directly after the write, therefore makes the commit and the read capture fall on the same edge. The bench provokes this with back-to-back write and read tasks. It judges the result by requiring the new word on `rdata_o` one time step after that edge. The bench also raises sleep in the middle of a registered read cycle and expects the drive to drop with no clock edge.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/sram_ft_capture.sv
module sram_ft_capture
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              we_i,
  input  logic              gwe_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              sleep_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DW-1:0]     wdata_q_o,
  output logic [LANES-1:0]  wmask_q_o,
  output cyc_kind_e         kind_q_o
);
  logic [LANES-1:0] mask_d;
  cyc_kind_e        kind_d;

  always_comb begin
    mask_d = '0;
    kind_d = CYC_IDLE;
    if (cs_i) begin
      if (gwe_i) begin
        mask_d = '1;
        kind_d = CYC_WRITE;
      end else if (we_i) begin
        mask_d = be_i;
        kind_d = CYC_WRITE;
      end else begin
        kind_d = CYC_READ;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      wmask_q_o <= '0;
      kind_q_o  <= CYC_IDLE;
    end else if (sleep_i) begin
      // sleep: start nothing new
      wmask_q_o <= '0;
      kind_q_o  <= CYC_IDLE;
    end else begin
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
      wmask_q_o <= mask_d;
      kind_q_o  <= kind_d;
    end
  end
endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic [DW-1:0]     wdata_q_i,
  input  logic [LANES-1:0]  wmask_q_i,
  output logic [DW-1:0]     rd_word_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    // commit at the edge closing the write cycle
    always_ff @(posedge clk_i) begin
      if (wmask_q_i[l]) mem[addr_q_i] <= wdata_q_i[l*LANE_W +: LANE_W];
    end

    assign rd_word_o[l*LANE_W +: LANE_W] = mem[addr_q_i];
  end
endmodule

// File: rtl/sram_ft_outgate.sv
module sram_ft_outgate
  import sram_ft_pkg::*;
#(
  parameter int DW = 36
) (
  input  logic          oe_i,
  input  logic          sleep_i,
  input  cyc_kind_e     kind_q_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [DW-1:0] rdata_o,
  output logic          dq_oe_o
);
  always_comb begin
    dq_oe_o = oe_i && !sleep_i && (kind_q_i == CYC_READ);
    rdata_o = dq_oe_o ? rd_word_i : '0;
  end
endmodule

// File: rtl/sync_ft_sram.sv
module sync_ft_sram
  import sram_ft_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_i,
  input  logic [LANES-1:0]  be_i,
  input  logic              we_i,
  input  logic              gwe_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  output logic [DW-1:0]     rdata_o,
  output logic              dq_oe_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  wmask_q;
  cyc_kind_e         kind_q;
  logic [DW-1:0]     rd_word;

  sram_ft_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .cs_i      (cs_i),
    .be_i      (be_i),
    .we_i      (we_i),
    .gwe_i     (gwe_i),
    .wdata_i   (wdata_i),
    .sleep_i   (sleep_i),
    .addr_q_o  (addr_q),
    .wdata_q_o (wdata_q),
    .wmask_q_o (wmask_q),
    .kind_q_o  (kind_q)
  );

  sram_ft_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i     (clk_i),
    .addr_q_i  (addr_q),
    .wdata_q_i (wdata_q),
    .wmask_q_i (wmask_q),
    .rd_word_o (rd_word)
  );

  sram_ft_outgate #(.DW(DW)) u_outgate (
    .oe_i      (oe_i),
    .sleep_i   (sleep_i),
    .kind_q_i  (kind_q),
    .rd_word_i (rd_word),
    .rdata_o   (rdata_o),
    .dq_oe_o   (dq_oe_o)
  );
endmodule

// File: rtl/sram_ft_chk.sv
module sram_ft_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          we_i,
  input logic          gwe_i,
  input logic          oe_i,
  input logic          sleep_i,
  input logic [DW-1:0] rdata_o,
  input logic          dq_oe_o
);
  AST_SLEEP_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o); // R10
  AST_OE_GATES_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (!dq_oe_o && rdata_o == '0)); // R7
  AST_DESELECT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !sleep_i) |=> !dq_oe_o); // R8
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && (we_i || gwe_i) && !sleep_i) |=> !dq_oe_o); // R9
  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && !we_i && !gwe_i && !sleep_i) |=> (!oe_i || sleep_i || dq_oe_o)); // R6
endmodule

bind sync_ft_sram sram_ft_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .we_i    (we_i),
  .gwe_i   (gwe_i),
  .oe_i    (oe_i),
  .sleep_i (sleep_i),
  .rdata_o (rdata_o),
  .dq_oe_o (dq_oe_o)
);

// File: tb/sync_ft_sram_test.sv
`timescale 1ns/1ps
module sync_ft_sram_test;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              cs_i = 1'b0;
  logic [LANES-1:0]  be_i = '0;
  logic              we_i = 1'b0;
  logic              gwe_i = 1'b0;
  logic [DW-1:0]     wdata_i = '0;
  logic              oe_i = 1'b1;
  logic              sleep_i = 1'b0;
  logic [DW-1:0]     rdata_o;
  logic              dq_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sync_ft_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .cs_i(cs_i), .be_i(be_i),
    .we_i(we_i), .gwe_i(gwe_i), .wdata_i(wdata_i), .oe_i(oe_i), .sleep_i(sleep_i),
    .rdata_o(rdata_o), .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] m);
    logic [DW-1:0] r = old_w;
    for (int l = 0; l < LANES; l++)
      if (m[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  // drive one cycle at negedge, return 1ns after the capturing edge
  task automatic cyc(input logic cs, input logic we, input logic gwe,
                     input logic [LANES-1:0] be, input logic [ADDR_W-1:0] a,
                     input logic [DW-1:0] d);
    @(negedge clk_i);
    cs_i = cs; we_i = we; gwe_i = gwe; be_i = be; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp, input string req);
    cyc(1, 0, 0, '0, a, '0);
    chk({req, " drive"}, 64'(dq_oe_o), 64'd1);
    chk({req, " data"}, 64'(rdata_o), 64'(exp));
  endtask

  task automatic idle();
    cyc(0, 0, 0, '0, '0, '0);
  endtask

  task automatic t_reset();
    #1;
    chk("R11 drive in reset", 64'(dq_oe_o), 64'd0);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    idle();
    chk("R11 drive after reset", 64'(dq_oe_o), 64'd0);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] base = 36'h123456789;
    logic [DW-1:0] nw   = 36'hFEDCBA987;
    cyc(1, 0, 1, '0, 6'd3, base);
    cyc(1, 1, 0, 4'b0101, 6'd3, nw);  // R2 strobed write
    chk("R9 no drive in write", 64'(dq_oe_o), 64'd0);
    rd(6'd3, merge(base, nw, 4'b0101), "R2/R5 lanes 0,2");
    cyc(1, 1, 0, 4'b1000, 6'd3, 36'h0);
    rd(6'd3, merge(merge(base, nw, 4'b0101), 36'h0, 4'b1000), "R5 lane 3 only");
    idle();
  endtask

  task automatic t_global();
    cyc(1, 0, 1, 4'b0000, 6'd5, 36'hA5A5A5A5A);  // R3 strobes low, we low
    rd(6'd5, 36'hA5A5A5A5A, "R3 global write");
    cyc(1, 1, 0, 4'b1111, 6'd9, 36'h0F0F0F0F0);
    rd(6'd9, 36'h0F0F0F0F0, "R4 all strobes");
    idle();
  endtask

  task automatic t_we_nostrobe();
    cyc(1, 1, 0, 4'b0000, 6'd5, 36'h111111111);
    chk("R12 no drive", 64'(dq_oe_o), 64'd0);
    rd(6'd5, 36'hA5A5A5A5A, "R12 unchanged");
    idle();
  endtask

  task automatic t_oe();
    oe_i = 1'b0;
    cyc(1, 0, 0, '0, 6'd5, '0);
    chk("R7 oe low drive", 64'(dq_oe_o), 64'd0);
    chk("R7 oe low data", 64'(rdata_o), 64'd0);
    oe_i = 1'b1;
    #0.5;
    chk("R7 oe async data", 64'(rdata_o), 64'(36'hA5A5A5A5A));
    idle();
  endtask

  task automatic t_deselect();
    rd(6'd9, 36'h0F0F0F0F0, "R8 before");
    idle();
    chk("R8 deselect next cycle", 64'(dq_oe_o), 64'd0);
    cyc(0, 0, 1, '0, 6'd9, 36'hFFFFFFFFF);
    rd(6'd9, 36'h0F0F0F0F0, "R8 deselected write ignored");
    idle();
  endtask

  task automatic t_back_to_back();
    cyc(1, 0, 1, '0, 6'd7, 36'hC3C3C3C3C);
    chk("R9 write cycle no drive", 64'(dq_oe_o), 64'd0);
    rd(6'd7, 36'hC3C3C3C3C, "R9 read right after write");
    idle();
  endtask

  task automatic t_registered();
    rd(6'd3, merge(merge(36'h123456789, 36'hFEDCBA987, 4'b0101), 36'h0, 4'b1000), "R1 flow-through");
    addr_i = 6'd5;
    #1;
    chk("R1 addr change between edges", 64'(rdata_o),
        64'(merge(merge(36'h123456789, 36'hFEDCBA987, 4'b0101), 36'h0, 4'b1000)));
    idle();
  endtask

  task automatic t_sleep();
    cyc(1, 0, 0, '0, 6'd7, '0);
    sleep_i = 1'b1;
    #0.5;
    chk("R10 sleep drops drive", 64'(dq_oe_o), 64'd0);
    cyc(1, 0, 1, '0, 6'd7, 36'h000000001);
    cyc(1, 0, 0, '0, 6'd7, '0);
    chk("R10 no read in sleep", 64'(dq_oe_o), 64'd0);
    @(negedge clk_i) sleep_i = 1'b0;
    rd(6'd7, 36'hC3C3C3C3C, "R10 contents retained");
    idle();
  endtask

  initial begin
    t_reset();
    t_lanes();
    t_global();
    t_we_nostrobe();
    t_oe();
    t_deselect();
    t_back_to_back();
    t_registered();
    t_sleep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule